// File: doc/BRIEF.md
# Line-by-line colour channel sequencer

This block decides which colour channel a linear image sensor front end works on at any moment. It drives two 2-bit selects. One steers the analog input multiplexer. The other picks the gain and offset register set. Each select is taken either from a static register value or from an internal colour counter. An external cycle pin advances that counter through red, green and blue, then back to red. The master clock samples the pin through a synchronizer, and each high pulse gives exactly one step.

When line-by-line colour mode is enabled, the block forces mono operation. It also raises power-down flags for the green and blue processing channels, because only the red path carries the signal. When line-by-line mode is off, a single channel register drives both selects.

In line-by-line mode, two control bits pick the source of each select: a force bit and an auto-cycle bit. With the force bit set, the input multiplexer follows its own dedicated register. The gain/offset select is then set independently: it follows the shared register, or it auto-cycles.

Top module: `lbl_colour_seq`

## Requirements
- R1: After active-low reset, the colour counter is red (code 00). With line-by-line and auto-cycle enabled, both selects read 00 until the first cycle pulse.
- R2: When `lbl_en` is 1, `pd_green`, `pd_blue` and `mono_force` are all 1. When `lbl_en` is 0, both power-down flags are 0 and `mono_force` equals `mono_en`.
- R3: When `lbl_en` is 0, `in_sel` and `gain_sel` both equal `chan_reg`, and a value of 11 is output as 00 (red). Colour codes are 00 = red, 01 = green, 10 = blue.
- R4: With `lbl_en`=1, `force_en`=0 and `acyc_en`=0, `in_sel` and `gain_sel` both equal `intm_reg`, with 11 output as 00.
- R5: With `lbl_en`=1, `force_en`=0 and `acyc_en`=1, both selects equal the colour counter. The counter steps 00→01→10→00 on each cycle pulse.
- R6: After `cycle_pin` is first sampled high at rising edge k, the counter changes at rising edge k+2 and not earlier. A high pulse of any length gives exactly one step.
- R7: With `lbl_en`=1 and `force_en`=1, `in_sel` equals `fm_reg`, with 11 output as 00. `gain_sel` equals `intm_reg` (11 output as 00) when `acyc_en`=0, and equals the colour counter when `acyc_en`=1.
- R8: When cycling is not active (`lbl_en`=0 or `acyc_en`=0), pulses on `cycle_pin` leave both selects unchanged.
- R9: On the first cycle in which cycling becomes active after being inactive, the counter reloads red (00), and the selects show 00 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_pin | input | 1 | Asynchronous external colour-advance pulse |
| lbl_en | input | 1 | Line-by-line colour mode enable |
| mono_en | input | 1 | Mono operation request outside line-by-line mode |
| acyc_en | input | 1 | Auto-cycle enable (1 = the pin advances the colour) |
| force_en | input | 1 | Force bit: input mux follows `fm_reg` |
| chan_reg | input | 2 | Channel register used outside line-by-line mode |
| intm_reg | input | 2 | Shared colour register in line-by-line mode |
| fm_reg | input | 2 | Dedicated input-mux colour register |
| in_sel | output | 2 | Input multiplexer colour select |
| gain_sel | output | 2 | Gain/offset register bank select |
| mono_force | output | 1 | Mono operation in effect |
| pd_green | output | 1 | Green processing channel power-down |
| pd_blue | output | 1 | Green/blue: blue processing channel power-down |

## Verification
The assertions assume that the register inputs are static while a cycle pulse passes through the synchronizer. They also assume that the cycle pin stays low long enough between pulses for the synchronizer to return to low. The stimulus therefore changes register values only at falling clock edges while the pin is idle. Each pulse is followed by several low cycles before the next pulse or mode change. Every register combination is swept with the pin held low, and cycling sequences use pulse widths from one to several clocks.

// File: rtl/clrseq_pkg.sv
package clrseq_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    COL_RED   = 2'b00,
    COL_GREEN = 2'b01,
    COL_BLUE  = 2'b10
  } colour_t;

  // Register value to colour; the unused code maps to red.
  function automatic colour_t reg_to_colour(input logic [SEL_W-1:0] v);
    case (v)
      2'b01:   reg_to_colour = COL_GREEN;
      2'b10:   reg_to_colour = COL_BLUE;
      default: reg_to_colour = COL_RED;
    endcase
  endfunction

  // Fixed cycling order red -> green -> blue -> red.
  function automatic colour_t next_colour(input colour_t c);
    case (c)
      COL_RED:   next_colour = COL_GREEN;
      COL_GREEN: next_colour = COL_BLUE;
      default:   next_colour = COL_RED;
    endcase
  endfunction

endpackage

// File: rtl/clrseq_edge_sync.sv
module clrseq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  // Shift chain, one flop per stage.
  assign sync_d[0] = async_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign sync_d[g] = sync_q[g-1];
  end

  assign last_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6

endmodule

// File: rtl/clrseq_cycler.sv
module clrseq_cycler
  import clrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    active_i,
  input  logic    step_i,
  output colour_t colour_o
);

  colour_t cnt_q;
  colour_t cnt_d;
  logic    prev_q;
  logic    enter;
  logic    cnt_en;

  assign enter  = active_i & ~prev_q;
  assign cnt_en = enter | (active_i & step_i);

  always_comb begin
    cnt_d = cnt_q;
    if (enter) begin
      cnt_d = COL_RED;
    end else if (step_i) begin
      cnt_d = next_colour(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= COL_RED;
      prev_q <= 1'b0;
    end else begin
      prev_q <= active_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign colour_o = cnt_q;

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && prev_q && step_i) |=> (cnt_q == next_colour($past(cnt_q)))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i) |=> $stable(cnt_q)); // R8
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && prev_q && !step_i) |=> $stable(cnt_q)); // R6
  AST_RELOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !prev_q) |=> (cnt_q == COL_RED)); // R9
  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'b11); // R5

endmodule

// File: rtl/clrseq_route.sv
module clrseq_route
  import clrseq_pkg::*;
(
  input  logic             lbl_en,
  input  logic             acyc_en,
  input  logic             force_en,
  input  logic [SEL_W-1:0] chan_reg,
  input  logic [SEL_W-1:0] intm_reg,
  input  logic [SEL_W-1:0] fm_reg,
  input  colour_t          cnt_i,
  output colour_t          in_sel_o,
  output colour_t          gain_sel_o
);

  colour_t chan_c;
  colour_t intm_c;
  colour_t fm_c;
  colour_t bank_c;

  assign chan_c = reg_to_colour(chan_reg);
  assign intm_c = reg_to_colour(intm_reg);
  assign fm_c   = reg_to_colour(fm_reg);

  // Source shared by gain/offset select and the unforced input select.
  assign bank_c = acyc_en ? cnt_i : intm_c;

  always_comb begin
    if (!lbl_en) begin
      in_sel_o   = chan_c;
      gain_sel_o = chan_c;
    end else begin
      gain_sel_o = bank_c;
      in_sel_o   = force_en ? fm_c : bank_c;
    end
  end

  always_comb begin
    AST_SEL_LEGAL: assert (in_sel_o != 2'b11 && gain_sel_o != 2'b11); // R3
  end

endmodule

// File: rtl/lbl_colour_seq.sv
module lbl_colour_seq
  import clrseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_pin,
  input  logic       lbl_en,
  input  logic       mono_en,
  input  logic       acyc_en,
  input  logic       force_en,
  input  logic [1:0] chan_reg,
  input  logic [1:0] intm_reg,
  input  logic [1:0] fm_reg,
  output logic [1:0] in_sel,
  output logic [1:0] gain_sel,
  output logic       mono_force,
  output logic       pd_green,
  output logic       pd_blue
);

  logic    step;
  logic    cyc_active;
  colour_t cnt;
  colour_t in_c;
  colour_t gain_c;

  assign cyc_active = lbl_en & acyc_en;

  clrseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cycle_pin),
    .rise_o  (step)
  );

  clrseq_cycler u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (cyc_active),
    .step_i   (step),
    .colour_o (cnt)
  );

  clrseq_route u_route (
    .lbl_en     (lbl_en),
    .acyc_en    (acyc_en),
    .force_en   (force_en),
    .chan_reg   (chan_reg),
    .intm_reg   (intm_reg),
    .fm_reg     (fm_reg),
    .cnt_i      (cnt),
    .in_sel_o   (in_c),
    .gain_sel_o (gain_c)
  );

  assign in_sel     = in_c;
  assign gain_sel   = gain_c;
  assign mono_force = lbl_en | mono_en;
  assign pd_green   = lbl_en;
  assign pd_blue    = lbl_en;

  AST_LBL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_green || pd_blue) |-> mono_force); // R2
  AST_LOCKED_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (lbl_en && acyc_en && !force_en) |-> (in_sel == gain_sel)); // R5

endmodule

// File: tb/sim_lbl_colour_seq.sv
module sim_lbl_colour_seq;

  logic       clk;
  logic       rst_n;
  logic       cycle_pin;
  logic       lbl_en;
  logic       mono_en;
  logic       acyc_en;
  logic       force_en;
  logic [1:0] chan_reg;
  logic [1:0] intm_reg;
  logic [1:0] fm_reg;
  logic [1:0] in_sel;
  logic [1:0] gain_sel;
  logic       mono_force;
  logic       pd_green;
  logic       pd_blue;

  int checks;
  int failures;

  lbl_colour_seq u0 (
    .clk(clk), .rst_n(rst_n), .cycle_pin(cycle_pin), .lbl_en(lbl_en),
    .mono_en(mono_en), .acyc_en(acyc_en), .force_en(force_en),
    .chan_reg(chan_reg), .intm_reg(intm_reg), .fm_reg(fm_reg),
    .in_sel(in_sel), .gain_sel(gain_sel), .mono_force(mono_force),
    .pd_green(pd_green), .pd_blue(pd_blue)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] san(input logic [1:0] v);
    san = (v == 2'b11) ? 2'b00 : v;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // One pulse of the given width; expects old colour 2 edges after the
  // first sampling edge, new colour one edge later.
  task automatic pulse(input int width, input logic [1:0] old_c,
                       input logic [1:0] new_c, input logic forced);
    cycle_pin = 1'b1;
    tick(1);
    if (width <= 1) cycle_pin = 1'b0;
    tick(1);
    if (width <= 2) cycle_pin = 1'b0;
    chk("R6 early", {2'b00, gain_sel}, {2'b00, old_c});
    tick(1);
    chk("R6 step", {2'b00, gain_sel}, {2'b00, new_c});
    if (!forced) chk("R5 in_sel", {2'b00, in_sel}, {2'b00, new_c});
    else         chk("R7 in_sel", {2'b00, in_sel}, {2'b00, san(fm_reg)});
    if (width > 3) tick(width - 3);
    cycle_pin = 1'b0;
    tick(4);
    chk("R6 single", {2'b00, gain_sel}, {2'b00, new_c});
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    cycle_pin = 1'b0;
    lbl_en = 1'b1;
    mono_en = 1'b0;
    acyc_en = 1'b1;
    force_en = 1'b0;
    chan_reg = 2'b00;
    intm_reg = 2'b10;
    fm_reg = 2'b01;
    tick(3);
    // R1: reset state
    chk("R1 reset gain", {2'b00, gain_sel}, 4'h0);
    chk("R1 reset in", {2'b00, in_sel}, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after release", {2'b00, gain_sel}, 4'h0);

    // Static sweep with the pin low: R2, R3, R4, R7
    acyc_en = 1'b0;
    for (int l = 0; l < 2; l++) begin
      for (int f = 0; f < 2; f++) begin
        for (int m = 0; m < 2; m++) begin
          for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 4; i++) begin
              for (int k = 0; k < 4; k++) begin
                lbl_en = l[0]; force_en = f[0]; mono_en = m[0];
                chan_reg = c[1:0]; intm_reg = i[1:0]; fm_reg = k[1:0];
                tick(1);
                chk("R2 pd_green", {3'b000, pd_green}, {3'b000, l[0]});
                chk("R2 pd_blue", {3'b000, pd_blue}, {3'b000, l[0]});
                chk("R2 mono_force", {3'b000, mono_force}, {3'b000, l[0] | m[0]});
                if (l == 0) begin
                  chk("R3 in_sel", {2'b00, in_sel}, {2'b00, san(c[1:0])});
                  chk("R3 gain_sel", {2'b00, gain_sel}, {2'b00, san(c[1:0])});
                end else if (f == 0) begin
                  chk("R4 in_sel", {2'b00, in_sel}, {2'b00, san(i[1:0])});
                  chk("R4 gain_sel", {2'b00, gain_sel}, {2'b00, san(i[1:0])});
                end else begin
                  chk("R7 in_sel", {2'b00, in_sel}, {2'b00, san(k[1:0])});
                  chk("R7 gain_sel", {2'b00, gain_sel}, {2'b00, san(i[1:0])});
                end
              end
            end
          end
        end
      end
    end

    // Auto-cycle, unforced: R5, R6, R9
    lbl_en = 1'b1; force_en = 1'b0; mono_en = 1'b0;
    intm_reg = 2'b10; fm_reg = 2'b01;
    acyc_en = 1'b1;
    tick(2);
    chk("R9 entry red", {2'b00, gain_sel}, 4'h0);
    for (int p = 0; p < 7; p++) begin
      pulse((p % 4) + 1, 2'(p % 3), 2'((p + 1) % 3), 1'b0);
    end

    // R8: pulses ignored when auto-cycle is off, then on re-entry red (R9)
    acyc_en = 1'b0;
    intm_reg = 2'b01;
    tick(2);
    for (int p = 0; p < 3; p++) begin
      cycle_pin = 1'b1; tick(2); cycle_pin = 1'b0; tick(4);
      chk("R8 acyc off gain", {2'b00, gain_sel}, 4'h1);
      chk("R8 acyc off in", {2'b00, in_sel}, 4'h1);
    end
    lbl_en = 1'b0; acyc_en = 1'b1; chan_reg = 2'b10;
    tick(2);
    cycle_pin = 1'b1; tick(2); cycle_pin = 1'b0; tick(4);
    chk("R8 lbl off", {2'b00, gain_sel}, 4'h2);
    lbl_en = 1'b1;
    tick(2);
    chk("R9 re-entry red", {2'b00, gain_sel}, 4'h0);

    // Forced input mux with auto-cycled bank: R7
    force_en = 1'b1; fm_reg = 2'b11;
    tick(1);
    chk("R7 forced 11 red", {2'b00, in_sel}, 4'h0);
    fm_reg = 2'b10;
    for (int p = 0; p < 5; p++) begin
      pulse(p + 1, 2'(p % 3), 2'((p + 1) % 3), 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule